// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Signed Relations

This block is a registered integer arithmetic logic unit. Its datapath is a chain of identical one-bit slices. A ripple carry runs through the chain from bit 0 to the top bit. A small decoder turns a 4-bit operation code into per-slice controls: operand inversion, carry-in and a slice output select. From these controls the unit gives bitwise AND, OR, NOR and NAND, two's-complement addition and subtraction, and a set-on-relation operation. For NOR and NAND, the slices invert both operands and then apply AND or OR.

For the relation operation the slices subtract the second operand from the first. A relation unit takes two terms from the difference: the signed less-than, which is the difference sign XOR overflow, and equality, which is an all-zero difference. A 3-bit relation select picks one of six signed relations. The chosen bit goes back into the least significant slice, so a true relation reads as the value 1. The result and the zero, carry and overflow flags are registered on the rising clock edge. An active-low reset clears them.

Top module: `sliced_alu`

## Requirements
- R1: While `rst_n` is 0, `result`, `zero`, `carry` and `ovf` are 0, whatever the other inputs are. Asserting reset clears them at once, without waiting for a clock edge.
- R2: Outputs change only at a rising clock edge. The values seen after an edge belong to the inputs present at that edge, which gives one cycle of latency.
- R3: Operation codes 0000, 0001, 1100 and 1101 give the bitwise AND, OR, NOR and NAND of `src_a` and `src_b`.
- R4: Operation code 0010 gives `src_a + src_b` and code 0110 gives `src_a - src_b`, both modulo 2^32.
- R5: Operation code 0111 gives a signed relation of `src_a` to `src_b`, chosen by `rel_sel`: 000 less, 001 greater, 010 less-or-equal, 011 greater-or-equal, 110 equal, 100 not-equal. A true relation gives the result 1, and a false one gives 0. Codes 101 and 111 always give 0.
- R6: For every defined operation code, `zero` is 1 exactly when all 32 result bits are 0.
- R7: `carry` is the carry out of the top slice for ADD and for SUB. SUB is computed as `src_a + ~src_b + 1`, so for SUB `carry` is 1 when `src_a >= src_b` unsigned. For every other operation `carry` is 0.
- R8: `ovf` is 1 only when ADD or SUB overflows as a signed 32-bit operation. For every other operation it is 0.
- R9: An operation code outside the seven listed gives a result of 0, with `zero`, `carry` and `ovf` all 0.
- R10: `rel_sel` has no effect on the outputs unless the operation code is 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs register on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| op_code | input | 4 | Operation select |
| rel_sel | input | 3 | Relation select, used with op_code 0111 |
| result | output | 32 | Registered result |
| zero | output | 1 | Result is all zeros (defined operations only) |
| carry | output | 1 | Top-slice carry out for ADD and SUB |
| ovf | output | 1 | Signed overflow for ADD and SUB |

## Verification
The assertions assume that `op_code`, `rel_sel` and both operands are stable and known around each rising edge. They also assume that the sampled inputs stay meaningful only while reset is released. Each property compares the registered outputs with the inputs of the cycle before, so an input that changes close to the edge would break that link. To keep within these assumptions, the bench changes every input only on the falling edge. It deliberately includes the undefined operation codes and the two unused relation codes. It also drives random relation selects under every non-relation operation, so that the "no effect" properties are actually exercised.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam logic [3:0] OPC_AND  = 4'b0000;
    localparam logic [3:0] OPC_OR   = 4'b0001;
    localparam logic [3:0] OPC_ADD  = 4'b0010;
    localparam logic [3:0] OPC_SUB  = 4'b0110;
    localparam logic [3:0] OPC_REL  = 4'b0111;
    localparam logic [3:0] OPC_NOR  = 4'b1100;
    localparam logic [3:0] OPC_NAND = 4'b1101;

    localparam logic [2:0] REL_LT = 3'b000;
    localparam logic [2:0] REL_GT = 3'b001;
    localparam logic [2:0] REL_LE = 3'b010;
    localparam logic [2:0] REL_GE = 3'b011;
    localparam logic [2:0] REL_NE = 3'b100;
    localparam logic [2:0] REL_EQ = 3'b110;

    typedef enum logic [1:0] {
        PICK_AND  = 2'b00,
        PICK_OR   = 2'b01,
        PICK_SUM  = 2'b10,
        PICK_LESS = 2'b11
    } slice_pick_e;

    typedef struct packed {
        logic        valid;
        logic        inv_a;
        logic        inv_b;
        logic        carry_in;
        logic        arith;
        slice_pick_e pick;
    } slice_ctl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [3:0] op_code,
    output slice_ctl_t ctl
);
    always_comb begin
        ctl = '{valid: 1'b1, inv_a: 1'b0, inv_b: 1'b0, carry_in: 1'b0,
                arith: 1'b0, pick: PICK_AND};
        unique case (op_code)
            OPC_AND:  ctl.pick = PICK_AND;
            OPC_OR:   ctl.pick = PICK_OR;
            OPC_ADD: begin
                ctl.pick  = PICK_SUM;
                ctl.arith = 1'b1;
            end
            OPC_SUB: begin
                ctl.pick     = PICK_SUM;
                ctl.arith    = 1'b1;
                ctl.inv_b    = 1'b1;
                ctl.carry_in = 1'b1;
            end
            OPC_REL: begin
                ctl.pick     = PICK_LESS;
                ctl.inv_b    = 1'b1;
                ctl.carry_in = 1'b1;
            end
            OPC_NOR: begin
                ctl.pick  = PICK_AND;
                ctl.inv_a = 1'b1;
                ctl.inv_b = 1'b1;
            end
            OPC_NAND: begin
                ctl.pick  = PICK_OR;
                ctl.inv_a = 1'b1;
                ctl.inv_b = 1'b1;
            end
            default:  ctl.valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic        a,
    input  logic        b,
    input  logic        inv_a,
    input  logic        inv_b,
    input  logic        cin,
    input  logic        less,
    input  slice_pick_e pick,
    output logic        res,
    output logic        cout,
    output logic        sum
);
    logic a_eff;
    logic b_eff;

    always_comb begin
        a_eff = a ^ inv_a;
        b_eff = b ^ inv_b;
        sum   = a_eff ^ b_eff ^ cin;
        cout  = (a_eff & b_eff) | (cin & (a_eff ^ b_eff));
        unique case (pick)
            PICK_AND:  res = a_eff & b_eff;
            PICK_OR:   res = a_eff | b_eff;
            PICK_SUM:  res = sum;
            PICK_LESS: res = less;
            default:   res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_relation.sv
module alu_relation
    import alu_pkg::*;
(
    input  logic       lt,
    input  logic       eq,
    input  logic [2:0] rel_sel,
    output logic       set_bit
);
    always_comb begin
        unique case (rel_sel)
            REL_LT:  set_bit = lt;
            REL_GT:  set_bit = ~lt & ~eq;
            REL_LE:  set_bit = lt | eq;
            REL_GE:  set_bit = ~lt;
            REL_EQ:  set_bit = eq;
            REL_NE:  set_bit = ~eq;
            default: set_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic [3:0]       op_code,
    input  logic [2:0]       rel_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             carry,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             zero;
        logic             carry;
        logic             ovf;
    } alu_state_t;

    slice_ctl_t       ctl;
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] slice_res;
    logic [WIDTH-1:0] slice_sum;
    logic [WIDTH-1:0] slice_less;
    logic             ovf_raw;
    logic             rel_lt;
    logic             rel_eq;
    logic             set_bit;
    alu_state_t       state_d;
    alu_state_t       state_q;

    alu_decode u_decode (
        .op_code (op_code),
        .ctl     (ctl)
    );

    assign chain[0] = ctl.carry_in;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_slice
            if (i == 0) begin : g_lsb
                assign slice_less[i] = set_bit;
            end else begin : g_upper
                assign slice_less[i] = 1'b0;
            end
            alu_bit_slice u_bit (
                .a     (src_a[i]),
                .b     (src_b[i]),
                .inv_a (ctl.inv_a),
                .inv_b (ctl.inv_b),
                .cin   (chain[i]),
                .less  (slice_less[i]),
                .pick  (ctl.pick),
                .res   (slice_res[i]),
                .cout  (chain[i+1]),
                .sum   (slice_sum[i])
            );
        end
    endgenerate

    assign ovf_raw = chain[WIDTH] ^ chain[MSB];
    assign rel_lt  = slice_sum[MSB] ^ ovf_raw;
    assign rel_eq  = ~|slice_sum;

    alu_relation u_relation (
        .lt      (rel_lt),
        .eq      (rel_eq),
        .rel_sel (rel_sel),
        .set_bit (set_bit)
    );

    always_comb begin
        state_d       = '0;
        state_d.res   = ctl.valid ? slice_res : '0;
        state_d.zero  = ctl.valid & ~|state_d.res;
        state_d.carry = ctl.arith & chain[WIDTH];
        state_d.ovf   = ctl.arith & ovf_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result = state_q.res;
    assign zero   = state_q.zero;
    assign carry  = state_q.carry;
    assign ovf    = state_q.ovf;

    p_and_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_AND) |=> (result == ($past(src_a) & $past(src_b))));

    p_nor_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_NOR) |=> (result == ~($past(src_a) | $past(src_b))));

    p_add_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_ADD) |=> (result == $past(src_a) + $past(src_b)));

    p_rel_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_REL) |=> (result[WIDTH-1:1] == '0));

    p_zero_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        zero |-> (result == '0));

    p_flags_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_code == OPC_ADD || op_code == OPC_SUB) |=> (!carry && !ovf));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_ADD && src_a[MSB] != src_b[MSB]) |=> !ovf);

    p_bad_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'b0011 || op_code == 4'b1111) |=> (result == '0 && !zero));

endmodule

// File: tb/sliced_alu_test.sv
module sliced_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [3:0]  op_code = '0;
    logic [2:0]  rel_sel = '0;
    logic [31:0] result;
    logic        zero;
    logic        carry;
    logic        ovf;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          pending = 1'b0;
    bit          done    = 1'b0;
    logic [34:0] exp_q;
    string       exp_tag;

    sliced_alu uut (
        .clk (clk), .rst_n (rst_n), .src_a (src_a), .src_b (src_b),
        .op_code (op_code), .rel_sel (rel_sel), .result (result),
        .zero (zero), .carry (carry), .ovf (ovf)
    );

    always #4 clk = ~clk;

    function automatic logic [34:0] model(logic [3:0] op, logic [2:0] rs,
                                          logic [31:0] a, logic [31:0] b);
        logic [32:0] s;
        logic [31:0] r;
        logic c, v, ok, lt, eq, t;
        r = 0; c = 0; v = 0; ok = 1;
        lt = $signed(a) < $signed(b);
        eq = (a == b);
        case (op)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b1100: r = ~(a | b);
            4'b1101: r = ~(a & b);
            4'b0010: begin
                s = {1'b0, a} + {1'b0, b};
                r = s[31:0]; c = s[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            4'b0110: begin
                s = {1'b0, a} + {1'b0, ~b} + 33'd1;
                r = s[31:0]; c = s[32];
                v = (a[31] != b[31]) && (r[31] != a[31]);
            end
            4'b0111: begin
                case (rs)
                    3'b000:  t = lt;
                    3'b001:  t = !lt && !eq;
                    3'b010:  t = lt || eq;
                    3'b011:  t = !lt;
                    3'b110:  t = eq;
                    3'b100:  t = !eq;
                    default: t = 0;
                endcase
                r = {31'd0, t};
            end
            default: ok = 0;
        endcase
        return {r, ok && (r == 0), c, v};
    endfunction

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'b0000, 4'b0001, 4'b1100, 4'b1101: return "R3/R10";
            4'b0010, 4'b0110: return "R4/R10";
            4'b0111: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check1(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        check1(exp_tag, result, exp_q[34:3]);
        check1(exp_tag == "R9" ? "R9" : "R6", {31'd0, zero}, {31'd0, exp_q[2]});
        check1(exp_tag == "R9" ? "R9" : "R7", {31'd0, carry}, {31'd0, exp_q[1]});
        check1(exp_tag == "R9" ? "R9" : "R8", {31'd0, ovf}, {31'd0, exp_q[0]});
    endtask

    task automatic drive(logic [3:0] op, logic [2:0] rs, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        if (pending) compare_all();
        op_code = op; rel_sel = rs; src_a = a; src_b = b;
        exp_q = model(op, rs, a, b);
        exp_tag = tag_of(op);
        pending = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (pending) compare_all();
        pending = 1'b0;
    endtask

    task automatic check_cleared(string req);
        check1(req, result, 32'd0);
        check1(req, {29'd0, zero, carry, ovf}, 32'd0);
    endtask

    initial begin
        // R1: reset holds outputs at zero while inputs are live
        op_code = 4'b0010; src_a = 32'h1234; src_b = 32'h1;
        repeat (3) @(negedge clk);
        check_cleared("R1");
        rst_n = 1'b1;

        // R2: output changes only at the clock edge
        drive(4'b0010, 3'b000, 32'd1, 32'd1);
        flush();
        op_code = 4'b0000; src_a = 32'd0; src_b = 32'd0;
        #1 check1("R2", result, 32'd2);
        flush();

        // R10: rel_sel changes under ADD leave the result alone
        drive(4'b0010, 3'b011, 32'd7, 32'd9);
        drive(4'b0010, 3'b101, 32'd7, 32'd9);
        flush();

        // R4 R7 R8 corner cases
        drive(4'b0010, 3'b0, 32'h7fffffff, 32'd1);
        drive(4'b0010, 3'b0, 32'h80000000, 32'h80000000);
        drive(4'b0010, 3'b0, 32'hffffffff, 32'd1);
        drive(4'b0110, 3'b0, 32'd0, 32'd1);
        drive(4'b0110, 3'b0, 32'h80000000, 32'd1);
        drive(4'b0110, 3'b0, 32'd5, 32'd5);
        drive(4'b0110, 3'b0, 32'h7fffffff, 32'hffffffff);
        // R3 logic patterns
        drive(4'b0000, 3'b0, 32'hf0f0_1234, 32'hff00_ffff);
        drive(4'b0001, 3'b0, 32'h0000_0000, 32'h0000_0000);
        drive(4'b1100, 3'b0, 32'h0f0f_0000, 32'h00ff_0000);
        drive(4'b1101, 3'b0, 32'hffffffff, 32'hffffffff);
        // R5 every relation over corner pairs
        for (int p = 0; p < 5; p++) begin
            logic [31:0] pa, pb;
            case (p)
                0: begin pa = 32'd5;        pb = 32'd5;        end
                1: begin pa = 32'hffffffff; pb = 32'd1;        end
                2: begin pa = 32'd1;        pb = 32'hffffffff; end
                3: begin pa = 32'h80000000; pb = 32'h7fffffff; end
                default: begin pa = 32'h7fffffff; pb = 32'h80000000; end
            endcase
            for (int r = 0; r < 8; r++) drive(4'b0111, 3'(r), pa, pb);
        end
        // R9 undefined codes
        drive(4'b0011, 3'b0, 32'd0, 32'd0);
        drive(4'b1111, 3'b0, 32'hffff, 32'h1);
        drive(4'b1000, 3'b0, 32'h0, 32'h0);
        flush();

        // Random mix over all codes
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            if (k % 3 == 0) op = 4'b0111;
            drive(op, 3'($urandom_range(0, 7)), $urandom, (k % 7 == 0) ? 32'd0 : $urandom);
        end
        flush();

        // R1: reset mid-run clears asynchronously
        drive(4'b0010, 3'b0, 32'hffffffff, 32'hffffffff);
        flush();
        #1 rst_n = 1'b0;
        #1 check_cleared("R1");
        @(negedge clk);
        check_cleared("R1");
        rst_n = 1'b1;
        drive(4'b0110, 3'b0, 32'd3, 32'd10);
        flush();

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule